// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Counter

This block is a synchronous up/down counter that counts in decimal. It is built from identical one-digit cells, each holding one binary-coded-decimal digit (0 to 9). In its default form two cells are chained, so the count runs 00 to 99 upward and 99 to 00 downward, wrapping at both ends. Each cell raises a combinational terminal-count signal, and that signal enables the next-higher cell. The whole count therefore steps as one decimal number in a single clock.

The counter has an active-low clear that acts at once, without the clock. An enable input gates every clocked change. A load input, honoured only while enable is high, takes one 4-bit parallel value per digit, and any value above 9 is replaced by 0. An up/down select picks the direction. A registered wrap flag goes high for one cycle after a step on which every digit wrapped together.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `rst_n` is low, every digit is 0 and `wrap_flag` is 0 at once, without waiting for a clock edge, whatever the other inputs do.
- R2: On a rising edge with `enable` and `load` both high, each digit takes its 4-bit field of `load_value`: bits [3:0] go to the ones digit and bits [7:4] to the tens digit. Terminal counts are ignored during a load.
- R3: A load field above 9 (codes 10 to 15) places 0 in that digit.
- R4: On an edge with `enable` low, the count does not change, `load` and `load_value` are ignored, and `wrap_flag` is 0 in the following cycle.
- R5: With `enable` high, `load` low and `count_up` high, the two-digit number goes up by one on each edge. A ones digit of 9 becomes 0 and the tens digit goes up by one.
- R6: With `enable` high, `load` low and `count_up` low, the number goes down by one on each edge. A ones digit of 0 becomes 9 and the tens digit goes down by one.
- R7: Counting up from 99 gives 00, and `wrap_flag` is 1 for exactly the one cycle after that edge.
- R8: Counting down from 00 gives 99, and `wrap_flag` is 1 for exactly the one cycle after that edge.
- R9: `wrap_flag` is 0 after every other edge. This includes loads and steps where only the ones digit wraps.
- R10: Each digit output is always a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| enable | input | 1 | Gates every clocked change |
| load | input | 1 | Parallel load request, honoured only with enable high |
| count_up | input | 1 | 1 counts up, 0 counts down |
| load_value | input | 4*NUM_DIGITS | Load digits, ones digit in the lowest nibble |
| count_value | output | 4*NUM_DIGITS | Current digits, ones digit in the lowest nibble |
| wrap_flag | output | 1 | Registered flag for a full-count wrap |

## Verification
Several functions can land on the same edge, and the bench drives each such case on purpose. A load can arrive while the ones digit sits at its terminal value, so the carry into the tens digit is live. A load request can also arrive while enable is low, so the count is held. The bench drives the first case at 99 counting up and at 00 counting down, and the second with a load value different from the current count. The load must win with the wrap flag staying low, and the held count must not change. A cycle-by-cycle decimal reference model checks the digits and the flag after each edge. Weighted random stimulus then mixes these collisions with plain counting.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_INC  = 2'd2,
        STEP_DEC  = 2'd3
    } step_kind_t;

    typedef struct packed {
        bcd_t digit;
    } cell_state_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    function automatic bcd_t clamp_digit(input bcd_t raw);
        return (raw > bcd_t'(DIGIT_MAX)) ? '0 : raw;
    endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic load,
    input  logic count_up,
    input  logic chain_en,
    input  bcd_t load_digit,
    output bcd_t digit,
    output logic term_cnt
);
    cell_state_t state_d, state_q;
    step_kind_t  kind;
    logic        at_top, at_bottom;

    always_comb begin
        at_top    = (state_q.digit == bcd_t'(DIGIT_MAX));
        at_bottom = (state_q.digit == '0);
        term_cnt  = chain_en & (count_up ? at_top : at_bottom);

        if (enable && load)
            kind = STEP_LOAD;
        else if (chain_en)
            kind = count_up ? STEP_INC : STEP_DEC;
        else
            kind = STEP_HOLD;

        state_d = state_q;
        unique case (kind)
            STEP_LOAD: state_d.digit = clamp_digit(load_digit);
            STEP_INC:  state_d.digit = at_top ? '0 : state_q.digit + bcd_t'(1);
            STEP_DEC:  state_d.digit = at_bottom ? bcd_t'(DIGIT_MAX)
                                                 : state_q.digit - bcd_t'(1);
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign digit = state_q.digit;

    // R10
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= bcd_t'(DIGIT_MAX));

    // R3
    load_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load && load_digit > bcd_t'(DIGIT_MAX)) |=> digit == '0);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load && load_digit <= bcd_t'(DIGIT_MAX)) |=> digit == $past(load_digit));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> $stable(digit));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && !load && count_up && digit == bcd_t'(DIGIT_MAX)) |=> digit == '0);

    // R6
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && !load && !count_up && digit == '0) |=> digit == bcd_t'(DIGIT_MAX));
endmodule

// File: rtl/bcd_wrap_flag.sv
module bcd_wrap_flag
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic load,
    input  logic last_tc,
    output logic wrap_flag
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.flag = enable & ~load & last_tc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wrap_flag = state_q.flag;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load && last_tc) |=> wrap_flag);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || load || !last_tc) |=> !wrap_flag);
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          load,
    input  logic                          count_up,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] load_value,
    output logic [NUM_DIGITS*DIGIT_W-1:0] count_value,
    output logic                          wrap_flag
);
    localparam int VEC_W = NUM_DIGITS * DIGIT_W;

    logic [NUM_DIGITS:0] chain;

    assign chain[0] = enable;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        bcd_t dig;
        bcd_digit_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (enable),
            .load       (load),
            .count_up   (count_up),
            .chain_en   (chain[g]),
            .load_digit (load_value[g*DIGIT_W +: DIGIT_W]),
            .digit      (dig),
            .term_cnt   (chain[g+1])
        );
        assign count_value[g*DIGIT_W +: DIGIT_W] = dig;
    end

    bcd_wrap_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .load      (load),
        .last_tc   (chain[NUM_DIGITS]),
        .wrap_flag (wrap_flag)
    );

    // R1
    clear_state_chk: assert property (@(posedge clk)
        (!rst_n) |-> (count_value == VEC_W'(0) && !wrap_flag));

    // R8
    down_full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load && !count_up && count_value == VEC_W'(0))
            |=> wrap_flag);
endmodule

// File: tb/tb_bcd_updown_counter.sv
module tb_bcd_updown_counter;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       enable = 0, load = 0, count_up = 0;
    logic [7:0] load_value = '0;
    logic [7:0] count_value;
    logic       wrap_flag;

    int n_checks = 0, n_fail = 0;
    int model_val = 0;
    int model_flag = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bcd_updown_counter #(.NUM_DIGITS(2)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load(load),
        .count_up(count_up), .load_value(load_value),
        .count_value(count_value), .wrap_flag(wrap_flag));

    function automatic int dut_num();
        return int'(count_value[7:4]) * 10 + int'(count_value[3:0]);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit en, bit ld, bit up, logic [7:0] data);
        string tag;
        int ones, tens;
        enable = en; load = ld; count_up = up; load_value = data;
        @(posedge clk);
        if (!en) begin
            tag = "R4"; model_flag = 0;
        end else if (ld) begin
            ones = (data[3:0] > 9) ? 0 : int'(data[3:0]);
            tens = (data[7:4] > 9) ? 0 : int'(data[7:4]);
            tag = (data[3:0] > 9 || data[7:4] > 9) ? "R3" : "R2";
            model_val = tens * 10 + ones; model_flag = 0;
        end else if (up) begin
            tag = (model_val == 99) ? "R7" : "R5";
            model_flag = (model_val == 99);
            model_val = (model_val + 1) % 100;
        end else begin
            tag = (model_val == 0) ? "R8" : "R6";
            model_flag = (model_val == 0);
            model_val = (model_val + 99) % 100;
        end
        @(negedge clk);
        check(tag, dut_num(), model_val);
        check(model_flag ? tag : "R9", int'(wrap_flag), model_flag);
        check("R10", int'(count_value[3:0] <= 9 && count_value[7:4] <= 9), 1);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", int'(count_value), 0);
        check("R1", int'(wrap_flag), 0);
        rst_n = 1;
        @(negedge clk);
        step(1, 1, 1, 8'h97);                   // R2
        repeat (5) step(1, 0, 1, 8'h00);        // R5, R7: 98 99 00 01 02
        repeat (2) step(0, 1, 0, 8'h55);        // R4: load ignored
        repeat (4) step(1, 0, 0, 8'h00);        // R6: 01 00 99 98
        step(1, 1, 0, 8'h00);
        step(1, 0, 0, 8'h00);                   // R8: 00 -> 99
        step(1, 0, 1, 8'h00);                   // R7: 99 -> 00
        step(1, 1, 1, 8'h99);
        step(1, 1, 1, 8'h42);                   // load beats carry at 99 up
        step(1, 1, 0, 8'h00);
        step(1, 1, 0, 8'h31);                   // load beats borrow at 00 down
        step(1, 1, 1, 8'h9A);                   // R3: ones clamped -> 90
        step(1, 1, 1, 8'hF7);                   // R3: tens clamped -> 07
        step(1, 1, 1, 8'hCE);                   // R3: both -> 00
        step(1, 1, 1, 8'h09);
        step(1, 0, 1, 8'h00);                   // R9: ones-only wrap 09 -> 10
        step(1, 0, 0, 8'h00);                   // R9: 10 -> 09
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            step(r > 10, r < 22, $urandom_range(0, 1) == 1, 8'($urandom));
        end
        step(1, 1, 1, 8'h63);
        #5 rst_n = 0;                           // R1: mid-cycle clear
        #2;
        check("R1", int'(count_value), 0);
        check("R1", int'(wrap_flag), 0);
        enable = 1; load = 1; load_value = 8'h77;
        @(posedge clk); #2;
        check("R1", int'(count_value), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule